// File: doc/BRIEF.md
# Interrupt Entry Micro-Sequencer

This block runs the short chain of register transfers that begins interrupt service. While no request is pending it stands in for the instruction datapath by advancing the program counter by one every clock. When an interrupt request is taken, the counter is frozen and four single-cycle steps follow.

The four steps run in a fixed order:

1. The current counter value is copied into the memory buffer register.
2. The memory address register is loaded with a fixed save location.
3. The counter is loaded with a fixed service entry value.
4. The buffer contents are written to memory at the address held in the address register.

No condition is evaluated at any step. Every accepted request always saves the interrupted counter and then jumps to the entry value.

The save location and the entry value are elaboration-time parameters. The write goes out on a synchronous, single-cycle memory write port. Acknowledge is pulsed in the same cycle as the write, which marks the end of the sequence. Reset is asserted asynchronously (active low) and is expected to be released in step with the clock.

Top module: `irq_entry_seq`

## Requirements
- R1: While reset is asserted, `pc_o` equals RESET_PC, `mbr_o` and `mar_o` are zero, and `mem_we` and `irq_ack` are 0.
- R2: In an idle cycle with `irq_req` low, `pc_o` rises by exactly one at the next clock, wrapping from all ones to zero.
- R3: `irq_req` is sampled only when idle. A high sample starts the four-step sequence. A request level during steps one to four starts nothing extra and does not alter those steps.
- R4: The value saved in `mbr_o` (visible from the second cycle after acceptance) equals `pc_o` as it stood in the accepting cycle, not the entry value.
- R5: `mar_o` shows SAVE_ADDR from the third cycle after acceptance.
- R6: `pc_o` holds its accepted value during cycles one to three after acceptance and shows VECTOR in cycle four.
- R7: `mem_we` is 1 only in the fourth cycle after acceptance, for exactly one cycle per sequence, with `mem_addr` = SAVE_ADDR and `mem_wdata` = the saved counter.
- R8: `irq_ack` is a one-cycle pulse in the same cycle as the memory write, and is 0 at all other times.
- R9: The cycle after step four is idle. A request present there is accepted at once and saves VECTOR. Otherwise counting resumes from VECTOR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Interrupt request level, sampled when idle |
| irq_ack | output | 1 | One-cycle pulse at the end of the sequence |
| pc_o | output | PC_W | Program counter |
| mbr_o | output | PC_W | Memory buffer register |
| mar_o | output | PC_W | Memory address register |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | PC_W | Memory write address |
| mem_wdata | output | PC_W | Memory write data |

## Verification
The bench builds the block with RESET_PC = 0x0010, SAVE_ADDR = 0x00F0 and VECTOR = 0xFFFE. With the entry value two below the top of the counter range, a few idle cycles after a sequence carry the counter through its wrap to zero. The distinct constants also make a saved entry value easy to tell apart from a saved interrupted counter when a request is held across a whole sequence. A reset applied partway through a sequence confirms that no write escapes.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CAPT  = 3'd1,
    ST_ADDR  = 3'd2,
    ST_JUMP  = 3'd3,
    ST_STORE = 3'd4
  } seq_state_e;
endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req,
  output logic capt_en,
  output logic addr_en,
  output logic jump_en,
  output logic count_en,
  output logic store_en
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (irq_req) state_d = ST_CAPT;
      ST_CAPT:  state_d = ST_ADDR;
      ST_ADDR:  state_d = ST_JUMP;
      ST_JUMP:  state_d = ST_STORE;
      ST_STORE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign capt_en  = (state_q == ST_CAPT);
  assign addr_en  = (state_q == ST_ADDR);
  assign jump_en  = (state_q == ST_JUMP);
  assign store_en = (state_q == ST_STORE);
  assign count_en = (state_q == ST_IDLE) && !irq_req;
endmodule

// File: rtl/irq_seq_regs.sv
module irq_seq_regs #(
  parameter int unsigned          PC_W      = 16,
  parameter logic [PC_W-1:0]      RESET_PC  = '0,
  parameter logic [PC_W-1:0]      SAVE_ADDR = 16'h0100,
  parameter logic [PC_W-1:0]      VECTOR    = 16'h0040
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capt_en,
  input  logic            addr_en,
  input  logic            jump_en,
  input  logic            count_en,
  output logic [PC_W-1:0] pc_q,
  output logic [PC_W-1:0] mbr_q,
  output logic [PC_W-1:0] mar_q
);
  localparam logic [PC_W-1:0] ONE = PC_W'(1);

  logic [PC_W-1:0] pc_d, mbr_d, mar_d;

  always_comb begin
    pc_d  = pc_q;
    mbr_d = mbr_q;
    mar_d = mar_q;
    if (jump_en)       pc_d = VECTOR;
    else if (count_en) pc_d = pc_q + ONE;
    if (capt_en)       mbr_d = pc_q;
    if (addr_en)       mar_d = SAVE_ADDR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC;
      mbr_q <= '0;
      mar_q <= '0;
    end else begin
      pc_q  <= pc_d;
      mbr_q <= mbr_d;
      mar_q <= mar_d;
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int unsigned          PC_W      = 16,
  parameter logic [PC_W-1:0]      RESET_PC  = '0,
  parameter logic [PC_W-1:0]      SAVE_ADDR = 16'h0100,
  parameter logic [PC_W-1:0]      VECTOR    = 16'h0040
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_req,
  output logic            irq_ack,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] mbr_o,
  output logic [PC_W-1:0] mar_o,
  output logic            mem_we,
  output logic [PC_W-1:0] mem_addr,
  output logic [PC_W-1:0] mem_wdata
);
  logic capt_en, addr_en, jump_en, count_en, store_en;

  irq_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_req  (irq_req),
    .capt_en  (capt_en),
    .addr_en  (addr_en),
    .jump_en  (jump_en),
    .count_en (count_en),
    .store_en (store_en)
  );

  irq_seq_regs #(
    .PC_W      (PC_W),
    .RESET_PC  (RESET_PC),
    .SAVE_ADDR (SAVE_ADDR),
    .VECTOR    (VECTOR)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .capt_en  (capt_en),
    .addr_en  (addr_en),
    .jump_en  (jump_en),
    .count_en (count_en),
    .pc_q     (pc_o),
    .mbr_q    (mbr_o),
    .mar_q    (mar_o)
  );

  assign mem_we    = store_en;
  assign irq_ack   = store_en;
  assign mem_addr  = mar_o;
  assign mem_wdata = mbr_o;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int unsigned          PC_W      = 16,
  parameter logic [PC_W-1:0]      SAVE_ADDR = 16'h0100,
  parameter logic [PC_W-1:0]      VECTOR    = 16'h0040
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_req,
  input logic            irq_ack,
  input logic            mem_we,
  input logic [PC_W-1:0] mem_addr,
  input logic [PC_W-1:0] pc_o,
  input logic [PC_W-1:0] mbr_o
);
  logic [2:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cyc <= 3'd0;
    else if (cyc == 3'd0)          cyc <= irq_req ? 3'd1 : 3'd0;
    else if (cyc == 3'd4)          cyc <= 3'd0;
    else                           cyc <= cyc + 3'd1;
  end

  // R2
  count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 3'd0 && !irq_req) |=> (pc_o == $past(pc_o) + PC_W'(1)));

  // R4
  saved_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 3'd1) |=> (mbr_o == $past(pc_o)));

  // R6
  pc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 3'd1 || cyc == 3'd2) |=> $stable(pc_o));

  // R6
  vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 3'd4) |-> (pc_o == VECTOR));

  // R7
  write_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (cyc == 3'd4 && mem_addr == SAVE_ADDR));

  // R7
  write_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 3'd4) |-> mem_we);

  // R8
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

  // R8
  ack_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> mem_we);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(
  .PC_W      (PC_W),
  .SAVE_ADDR (SAVE_ADDR),
  .VECTOR    (VECTOR)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_req  (irq_req),
  .irq_ack  (irq_ack),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .pc_o     (pc_o),
  .mbr_o    (mbr_o)
);

// File: tb/test_irq_entry_seq.sv
`timescale 1ns/1ps
module test_irq_entry_seq;
  localparam int unsigned     PC_W  = 16;
  localparam logic [15:0]     RST_V = 16'h0010;
  localparam logic [15:0]     SAVE  = 16'h00F0;
  localparam logic [15:0]     VEC   = 16'hFFFE;

  logic clk = 1'b0;
  logic rst_n;
  logic irq_req;
  logic irq_ack, mem_we;
  logic [15:0] pc_o, mbr_o, mar_o, mem_addr, mem_wdata;

  int vectors = 0;
  int miscompares = 0;
  int writes_seen = 0;
  int writes_exp = 0;
  bit done = 1'b0;
  logic [15:0] exp_pc;
  logic [31:0] sb_q[$];

  always #2 clk = ~clk;

  irq_entry_seq #(
    .PC_W(PC_W), .RESET_PC(RST_V), .SAVE_ADDR(SAVE), .VECTOR(VEC)
  ) i_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
    .pc_o(pc_o), .mbr_o(mbr_o), .mar_o(mar_o), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: pops one expected write per observed write
  always @(negedge clk) begin
    if (rst_n === 1'b1 && mem_we === 1'b1) begin
      writes_seen++;
      chk("R8 ack with write", {15'd0, irq_ack}, 16'd1);
      if (sb_q.size() == 0) begin
        chk("R7 unexpected write", 16'hDEAD, 16'h0000);
      end else begin
        logic [31:0] item;
        item = sb_q.pop_front();
        chk("R7 write address", mem_addr, item[31:16]);
        chk("R7/R4 write data", mem_wdata, item[15:0]);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      irq_req = 1'b0;
      chk("R2 idle count", pc_o, exp_pc);
      chk("R7 no write idle", {15'd0, mem_we}, 16'd0);
      exp_pc = exp_pc + 16'd1;
    end
  endtask

  // hold=1 keeps irq_req high through the whole sequence (R3, R9)
  task automatic fire(input bit hold);
    logic [15:0] p;
    @(negedge clk);
    chk("R3 pc at accept", pc_o, exp_pc);
    p = exp_pc;
    irq_req = 1'b1;
    sb_q.push_back({SAVE, p});
    writes_exp++;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (!hold) irq_req = 1'b0;
      if (k < 4) begin
        chk("R6 pc frozen", pc_o, p);
        chk("R7 no early write", {15'd0, mem_we}, 16'd0);
        chk("R8 no early ack", {15'd0, irq_ack}, 16'd0);
      end else begin
        chk("R6 vector loaded", pc_o, VEC);
        chk("R8 ack pulse", {15'd0, irq_ack}, 16'd1);
      end
      if (k >= 2) chk("R4 mbr saved", mbr_o, p);
      if (k >= 3) chk("R5 mar loaded", mar_o, SAVE);
    end
    exp_pc = VEC;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    irq_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset pc", pc_o, RST_V);
    chk("R1 reset mbr", mbr_o, 16'h0000);
    chk("R1 reset mar", mar_o, 16'h0000);
    chk("R1 reset we", {15'd0, mem_we}, 16'd0);
    chk("R1 reset ack", {15'd0, irq_ack}, 16'd0);
    irq_req = 1'b0;
    rst_n = 1'b1;
    exp_pc = RST_V + 16'd1;

    idle(5);
    fire(1'b0);                 // saves a counted value
    idle(4);                    // R2 wrap: FFFE, FFFF, 0000, 0001
    fire(1'b0);
    idle(2);
    fire(1'b1);                 // R3 request held through the sequence
    fire(1'b0);                 // R9 accepted in first idle cycle, saves VEC
    idle(3);

    // reset in the middle of a sequence: no write may follow
    @(negedge clk);
    irq_req = 1'b1;
    @(negedge clk);
    irq_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 mid-seq reset pc", pc_o, RST_V);
    chk("R1 mid-seq reset we", {15'd0, mem_we}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_pc = RST_V + 16'd1;
    idle(6);
    fire(1'b0);
    idle(2);

    chk("R7 write count", 16'(writes_seen), 16'(writes_exp));
    chk("R7 scoreboard drained", 16'(sb_q.size()), 16'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule